// File: doc/BRIEF.md
# Sample-and-Hold Phase Sequencer

This block drives the power and switch controls of a low-power sample-and-hold converter output. Once the slow-domain enable rises, it runs one sample phase and then alternates between hold and refresh phases until it is disabled. During a sample or refresh phase the converter core and output buffer are driven and the pin is connected to the storage capacitor. During a hold phase the core and buffer are off and the output pin floats, so the capacitor holds the level alone. A restart input, raised when new data is written, sends the sequencer back to the sample phase.

Phase lengths are counted in cycles of a slow clock. Software sets them through a write port in the fast bus clock domain. The hold and refresh lengths are read at the start of each phase. The sample length crosses into the slow domain through a toggle handshake. A busy flag covers the crossing, so the sample length can be changed while the channel runs.

Top module: `sh_seq_top`

## Requirements
- R1: After reset, busy_o is 0, phase_o is 0 (idle), core_en_o and buf_en_o are 0, out_hiz_o is 1 and sample_sw_o is 0.
- R2: A sample-length field value of N gives a sample phase (phase_o = 1) of N+1 slow-clock cycles.
- R3: The hold-length field (wr_sel_i = 1, 10 bits) gives a hold phase (phase_o = 2) of that many slow cycles. A value of 0 gives 1 cycle.
- R4: The refresh-length field (wr_sel_i = 2, low 8 bits of wr_data_i, upper bits dropped) gives a refresh phase (phase_o = 3) of that many slow cycles. A value of 0 gives 1 cycle.
- R5: In hold and idle, core_en_o = 0, buf_en_o = 0, out_hiz_o = 1 and sample_sw_o = 0. In sample and refresh, these outputs are 1, 1, 0 and 1.
- R6: Once enabled, the order is sample, hold, refresh, hold, refresh, and so on.
- R7: An accepted write to the sample-length field (wr_sel_i = 0) sets busy_o from the next bus clock. busy_o clears after the value has reached the slow domain and the acknowledge has come back. The new value applies from the next sample phase that starts.
- R8: A sample-length write made while busy_o is 1 is ignored.
- R9: Hold and refresh lengths are captured when each phase starts. A rewrite during a phase does not change that phase's length.
- R10: ls_restart_i held high on a slow edge while enabled moves the sequencer to the sample phase on that edge.
- R11: With ls_en_i low, the next slow edge gives phase idle and clears the phase counter. A later enable begins with a full-length sample phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_en_i | input | 1 | Register write strobe (bus domain) |
| wr_sel_i | input | 2 | Field select: 0 sample, 1 hold, 2 refresh, 3 none |
| wr_data_i | input | 10 | Write data |
| busy_o | output | 1 | Sample-length crossing in progress |
| lsclk_i | input | 1 | Slow phase clock |
| ls_en_i | input | 1 | Channel enable (slow domain) |
| ls_restart_i | input | 1 | New data: return to sample (slow domain) |
| phase_o | output | 2 | 0 idle, 1 sample, 2 hold, 3 refresh |
| core_en_o | output | 1 | Converter core enable |
| buf_en_o | output | 1 | Output buffer enable |
| out_hiz_o | output | 1 | Output pin tri-state |
| sample_sw_o | output | 1 | Sample switch closed |

## Verification
A bad phase counter appears at the ports as a wrong phase length at the next phase boundary. A wrong next-state decision appears as an out-of-order phase on the first transition after the fault. A broken handshake shows as busy_o stuck high, or as a sample phase that keeps the old length after busy_o has cleared. A wrong power decode is visible on the first slow cycle of any phase.

// File: rtl/sh_seq_pkg.sv
package sh_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAMPLE  = 2'd1,
    PH_HOLD    = 2'd2,
    PH_REFRESH = 2'd3
  } phase_e;

  localparam logic [1:0] SEL_SAMPLE  = 2'd0;
  localparam logic [1:0] SEL_HOLD    = 2'd1;
  localparam logic [1:0] SEL_REFRESH = 2'd2;
endpackage

// File: rtl/sh_sync.sv
module sh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sh_cfg_regs.sv
module sh_cfg_regs
  import sh_seq_pkg::*;
#(
  parameter int SAM_W = 10,
  parameter int HLD_W = 10,
  parameter int REF_W = 8,
  parameter int DAT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DAT_W-1:0] wr_data_i,
  input  logic             ack_tog_i,
  output logic             busy_o,
  output logic             req_tog_o,
  output logic [SAM_W-1:0] tsam_o,
  output logic [HLD_W-1:0] thold_o,
  output logic [REF_W-1:0] tref_o
);
  logic sam_wr, sam_acc;

  assign busy_o  = req_tog_o ^ ack_tog_i;
  assign sam_wr  = wr_en_i && (wr_sel_i == SEL_SAMPLE);
  assign sam_acc = sam_wr && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tog_o <= 1'b0;
      tsam_o    <= '0;
      thold_o   <= '0;
      tref_o    <= '0;
    end else begin
      if (sam_acc) begin
        tsam_o    <= wr_data_i[SAM_W-1:0];
        req_tog_o <= ~req_tog_o;
      end
      if (wr_en_i && wr_sel_i == SEL_HOLD)    thold_o <= wr_data_i[HLD_W-1:0];
      if (wr_en_i && wr_sel_i == SEL_REFRESH) tref_o  <= wr_data_i[REF_W-1:0];
    end
  end

  p_busy_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sam_acc |=> busy_o);
  p_busy_write_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sam_wr && busy_o) |=> $stable(tsam_o) && $stable(req_tog_o));
endmodule

// File: rtl/sh_phase_fsm.sv
module sh_phase_fsm
  import sh_seq_pkg::*;
#(
  parameter int SAM_W = 10,
  parameter int HLD_W = 10,
  parameter int REF_W = 8,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             req_tog_i,
  input  logic [SAM_W-1:0] tsam_i,
  input  logic [HLD_W-1:0] thold_i,
  input  logic [REF_W-1:0] tref_i,
  output logic             ack_tog_o,
  output logic [1:0]       phase_o,
  output logic             core_en_o,
  output logic             buf_en_o,
  output logic             out_hiz_o,
  output logic             sample_sw_o
);
  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SAM_W-1:0]  tsam_q;
  logic [CNT_W-1:0]  hold_ld, ref_ld;

  function automatic logic [CNT_W-1:0] len_to_ld(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign hold_ld = len_to_ld(CNT_W'(thold_i));
  assign ref_ld  = len_to_ld(CNT_W'(tref_i));

  // handshake: shadow is stable while bus side is busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_tog_o <= 1'b0;
      tsam_q    <= '0;
    end else if (req_tog_i != ack_tog_o) begin
      tsam_q    <= tsam_i;
      ack_tog_o <= req_tog_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE || restart_i) begin
      phase_q <= PH_SAMPLE;
      cnt_q   <= CNT_W'(tsam_q);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else begin
      case (phase_q)
        PH_HOLD: begin
          phase_q <= PH_REFRESH;
          cnt_q   <= ref_ld;
        end
        default: begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_ld;
        end
      endcase
    end
  end

  always_comb begin
    core_en_o   = 1'b0;
    buf_en_o    = 1'b0;
    out_hiz_o   = 1'b1;
    sample_sw_o = 1'b0;
    if (phase_q == PH_SAMPLE || phase_q == PH_REFRESH) begin
      core_en_o   = 1'b1;
      buf_en_o    = 1'b1;
      out_hiz_o   = 1'b0;
      sample_sw_o = 1'b1;
    end
  end

  assign phase_o = phase_q;

  p_disable_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == PH_IDLE) && (cnt_q == '0));
  p_restart_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i) |=> phase_q == PH_SAMPLE);
  p_sample_to_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && phase_q == PH_SAMPLE && cnt_q == '0) |=> phase_q == PH_HOLD);
  p_hold_to_refresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !restart_i && phase_q == PH_HOLD && cnt_q == '0) |=> phase_q == PH_REFRESH);
  p_hold_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_HOLD) |-> (!core_en_o && !buf_en_o && out_hiz_o && !sample_sw_o));
endmodule

// File: rtl/sh_seq_top.sv
module sh_seq_top
  import sh_seq_pkg::*;
#(
  parameter int SAM_W    = 10,
  parameter int HLD_W    = 10,
  parameter int REF_W    = 8,
  parameter int SYNC_STG = 2,
  localparam int MAX_SH  = (SAM_W > HLD_W) ? SAM_W : HLD_W,
  localparam int DAT_W   = (MAX_SH > REF_W) ? MAX_SH : REF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DAT_W-1:0] wr_data_i,
  output logic             busy_o,
  input  logic             lsclk_i,
  input  logic             ls_en_i,
  input  logic             ls_restart_i,
  output logic [1:0]       phase_o,
  output logic             core_en_o,
  output logic             buf_en_o,
  output logic             out_hiz_o,
  output logic             sample_sw_o
);
  logic             req_tog, req_tog_ls, ack_tog, ack_tog_bus;
  logic [SAM_W-1:0] tsam;
  logic [HLD_W-1:0] thold;
  logic [REF_W-1:0] tref;

  sh_cfg_regs #(.SAM_W(SAM_W), .HLD_W(HLD_W), .REF_W(REF_W), .DAT_W(DAT_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .ack_tog_i(ack_tog_bus), .busy_o, .req_tog_o(req_tog),
    .tsam_o(tsam), .thold_o(thold), .tref_o(tref)
  );

  sh_sync #(.STAGES(SYNC_STG)) u_req_sync (
    .clk_i(lsclk_i), .rst_ni, .d_i(req_tog), .q_o(req_tog_ls)
  );

  sh_sync #(.STAGES(SYNC_STG)) u_ack_sync (
    .clk_i, .rst_ni, .d_i(ack_tog), .q_o(ack_tog_bus)
  );

  sh_phase_fsm #(.SAM_W(SAM_W), .HLD_W(HLD_W), .REF_W(REF_W), .CNT_W(DAT_W)) u_fsm (
    .clk_i(lsclk_i), .rst_ni, .en_i(ls_en_i), .restart_i(ls_restart_i),
    .req_tog_i(req_tog_ls), .tsam_i(tsam), .thold_i(thold), .tref_i(tref),
    .ack_tog_o(ack_tog), .phase_o, .core_en_o, .buf_en_o, .out_hiz_o, .sample_sw_o
  );
endmodule

// File: tb/sh_seq_top_tb_top.sv
module sh_seq_top_tb_top;
  logic       clk_i = 1'b0, lsclk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [9:0] wr_data_i = '0;
  logic       ls_en_i = 1'b0, ls_restart_i = 1'b0;
  logic       busy_o, core_en_o, buf_en_o, out_hiz_o, sample_sw_o;
  logic [1:0] phase_o;

  int n_vec = 0, n_bad = 0;
  logic [1:0] exp_ph[$];
  int         exp_len[$];
  logic [1:0] prev_ph = 2'd0;
  int         run_len = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;
  always #80 lsclk_i = ~lsclk_i;

  sh_seq_top dut_i (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .busy_o,
    .lsclk_i, .ls_en_i, .ls_restart_i, .phase_o,
    .core_en_o, .buf_en_o, .out_hiz_o, .sample_sw_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ph, input int len);
    exp_ph.push_back(ph);
    exp_len.push_back(len);
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [9:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_not_busy(input string req);
    int n = 0;
    while (busy_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    chk(!busy_o, req, busy_o, 0);
  endtask

  task automatic run_until_drained();
    wait (exp_ph.size() == 0);
    ls_en_i = 1'b0;
    repeat (2) @(negedge lsclk_i);
  endtask

  function automatic bit natural(input logic [1:0] a, input logic [1:0] b);
    return (a == 2'd1 && b == 2'd2) || (a == 2'd2 && b == 2'd3) || (a == 2'd3 && b == 2'd2);
  endfunction

  // monitor / scoreboard
  always @(negedge lsclk_i) begin
    if (rst_ni) begin
      logic on;
      on = (phase_o == 2'd1) || (phase_o == 2'd3);
      chk({core_en_o, buf_en_o, out_hiz_o, sample_sw_o} == {on, on, !on, on}, "R5",
          {core_en_o, buf_en_o, out_hiz_o, sample_sw_o}, {on, on, !on, on});
      if (phase_o != prev_ph) begin
        if (natural(prev_ph, phase_o)) begin
          if (exp_ph.size() == 0) begin
            chk(1'b0, "R6 unexpected run", prev_ph, 0);
          end else begin
            logic [1:0] eph;
            int elen;
            eph  = exp_ph.pop_front();
            elen = exp_len.pop_front();
            chk(prev_ph == eph, "R6 phase order", prev_ph, eph);
            chk(run_len == elen, (prev_ph == 2'd1) ? "R2 sample length" :
                (prev_ph == 2'd2) ? "R3 hold length" : "R4 refresh length", run_len, elen);
          end
        end
        run_len = 1;
      end else begin
        run_len++;
      end
      prev_ph = phase_o;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(phase_o == 2'd0, "R1 phase", phase_o, 0);
    chk({core_en_o, buf_en_o, out_hiz_o, sample_sw_o} == 4'b0010, "R1 outputs",
        {core_en_o, buf_en_o, out_hiz_o, sample_sw_o}, 4'b0010);

    bus_write(2'd1, 10'd6);
    bus_write(2'd2, 10'd2);
    bus_write(2'd0, 10'd3);
    chk(busy_o == 1'b1, "R7 busy set", busy_o, 1);
    bus_write(2'd0, 10'd5);   // R8: dropped while busy
    wait_not_busy("R7 busy clear");

    // R2 R3 R4 R6 basic loop; sample stays 4 (R8)
    push(2'd1, 4); push(2'd2, 6); push(2'd3, 2); push(2'd2, 6); push(2'd3, 2);
    @(negedge lsclk_i); ls_en_i = 1'b1;
    run_until_drained();
    chk(phase_o == 2'd0, "R11 idle after disable", phase_o, 0);

    // R10 restart from refresh; R11 re-enable gives full sample
    push(2'd1, 4); push(2'd2, 6);
    ls_en_i = 1'b1;
    wait (exp_ph.size() == 0);
    ls_restart_i = 1'b1;
    @(negedge lsclk_i);
    ls_restart_i = 1'b0;
    chk(phase_o == 2'd1, "R10 restart to sample", phase_o, 1);
    push(2'd1, 4); push(2'd2, 6);
    run_until_drained();

    // R7 live sample rewrite, R9 hold captured at phase start
    push(2'd1, 4);
    ls_en_i = 1'b1;
    wait (exp_ph.size() == 0);
    push(2'd2, 6); push(2'd3, 2); push(2'd2, 3);
    bus_write(2'd0, 10'd7);
    bus_write(2'd1, 10'd3);
    wait (exp_ph.size() == 0);
    chk(busy_o == 1'b0, "R7 busy clear while running", busy_o, 0);
    ls_restart_i = 1'b1;
    @(negedge lsclk_i);
    ls_restart_i = 1'b0;
    push(2'd1, 8); push(2'd2, 3);
    run_until_drained();

    // R3 R4 zero lengths, R2 zero sample
    bus_write(2'd1, 10'd0);
    bus_write(2'd2, 10'd0);
    bus_write(2'd0, 10'd0);
    wait_not_busy("R7 busy clear");
    push(2'd1, 1); push(2'd2, 1); push(2'd3, 1); push(2'd2, 1); push(2'd3, 1);
    @(negedge lsclk_i); ls_en_i = 1'b1;
    run_until_drained();

    // R4 upper data bits dropped for refresh field
    bus_write(2'd1, 10'd2);
    bus_write(2'd2, 10'h305);
    push(2'd1, 1); push(2'd2, 2); push(2'd3, 5); push(2'd2, 2);
    @(negedge lsclk_i); ls_en_i = 1'b1;
    run_until_drained();

    chk(exp_ph.size() == 0, "R6 queue drained", exp_ph.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule